// File: doc/BRIEF.md
# Digital PLL Calibration Sequencer

This block brings an on-chip digital PLL into lock by writing tuning bounds to the PLL's control register and then watching the PLL's ready flag. When a calibration run starts, the block computes a starting lower frequency bound from the reference clock and the target clock, both given in MHz. It adds a small delta to get the upper bound. It then writes both bounds with the tuning enable set. After that it polls the status byte until the PLL reports ready. A short stability window follows, and during it the ready flag must stay high without a break.

A passing attempt ends with one more control write. That write carries the same bounds with tuning turned off, and the block then raises its success flag. A failed attempt happens when the lock wait times out or the ready flag drops inside the window. After a failed attempt the lower bound is nudged up or down in an alternating pattern that widens with each try, and the block tries again. After the last permitted attempt fails, the block raises its failure flag.

Top module: `dpll_cal_seq`

## Requirements
- R1: After reset, `ctrl_wr`, `busy`, `cal_ok` and `cal_fail` are all low.
- R2: On the first attempt the lower bound is floor(`ref_mhz` × 48 / `tgt_mhz`). It is placed in `ctrl_word[15:0]`, and the upper bound (lower + delta) is placed in `ctrl_word[31:16]`.
- R3: The delta is 2 when `ref_mhz` is below 50 and 4 when it is 50 or more.
- R4: Every attempt begins with one `ctrl_wr` pulse whose word has bit 8 (the tuning enable) forced to 1.
- R5: Only bit 7 of `stat_byte` counts as the ready flag, and the other bits are ignored. Ready is sampled once every `POLL_CYCLES` clocks, for at most `LOCK_POLLS` samples. If ready is never seen, the attempt fails.
- R6: Once ready has been seen, it must stay at 1 on each of the next `HOLD_SAMPLES` clocks. A single low sample fails the attempt.
- R7: A passing attempt issues exactly one more `ctrl_wr` with the same bounds and bit 8 cleared. In that same cycle `cal_ok` rises and `busy` falls.
- R8: After attempt n fails (n counts from 0), the next attempt's lower bound is the previous lower bound minus n>>1 if n is odd, or plus n>>1 if n is even. The upper bound is recomputed from it.
- R9: If all `MAX_TRIES` (default 8) attempts fail, `cal_fail` rises, `busy` falls and no tuning-off write is issued.
- R10: `cal_ok` and `cal_fail` are never high together. Both are cleared when a new run is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a calibration run when the block is idle |
| ref_mhz | input | 8 | Reference clock frequency in MHz |
| tgt_mhz | input | 8 | Target PLL frequency in MHz, non-zero |
| stat_byte | input | 8 | PLL status byte; bit 7 is the ready flag |
| ctrl_wr | output | 1 | One-cycle write strobe for the PLL control word |
| ctrl_word | output | 32 | Control word: upper bound [31:16], lower bound [15:0], tuning enable at bit 8 |
| busy | output | 1 | A calibration run is in progress |
| cal_ok | output | 1 | The last run locked the PLL |
| cal_fail | output | 1 | The last run used up every attempt |

## Verification
The assertions assume a few things about the inputs. `start` is only raised while `busy` is low, `tgt_mhz` is non-zero, and `ref_mhz` and `tgt_mhz` stay constant for the whole run, because the delta and the divider use them as they stand when the run is accepted. The bench follows these rules. It changes the frequency inputs only between runs and uses non-zero targets. It also drives the status byte from a PLL model that sets all seven low bits to ones whenever ready is low, so a block that looked at the wrong bit would see a false lock.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int unsigned TUNE_BIT  = 8;
    localparam int unsigned READY_BIT = 7;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_DIV,
        SQ_ARM,
        SQ_WAIT
    } seq_state_e;

    typedef enum logic [1:0] {
        LM_IDLE,
        LM_POLL,
        LM_HOLD
    } lock_phase_e;
endpackage

// File: rtl/cal_divider.sv
module cal_divider #(
    parameter int unsigned NUM_W = 16,
    parameter int unsigned DEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int unsigned CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [NUM_W-1:0] dvd;
        logic [NUM_W-1:0] quo;
        logic [DEN_W:0]   rem;
        logic [DEN_W-1:0] den;
        logic             done;
    } div_s;

    div_s q, d;
    logic [DEN_W:0] rem_sh;
    logic           qbit;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        rem_sh = {q.rem[DEN_W-1:0], q.dvd[NUM_W-1]};
        qbit   = 1'b0;
        if (go) begin
            d.run = 1'b1;
            d.cnt = '0;
            d.dvd = num;
            d.quo = '0;
            d.rem = '0;
            d.den = den;
        end else if (q.run) begin
            if (rem_sh >= {1'b0, q.den}) begin
                d.rem = rem_sh - {1'b0, q.den};
                qbit  = 1'b1;
            end else begin
                d.rem = rem_sh;
            end
            d.quo = {q.quo[NUM_W-2:0], qbit};
            d.dvd = {q.dvd[NUM_W-2:0], 1'b0};
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CNT_W'(NUM_W - 1)) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;
    assign quo  = q.quo;

    // R2
    div_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !q.run);
endmodule

// File: rtl/cal_bound_stepper.sv
module cal_bound_stepper #(
    parameter int unsigned BND_W      = 16,
    parameter int unsigned REF_W      = 8,
    parameter int unsigned IDX_W      = 3,
    parameter int unsigned SPLIT_MHZ  = 50,
    parameter int unsigned DELTA_SLOW = 2,
    parameter int unsigned DELTA_FAST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BND_W-1:0] base,
    input  logic             nudge,
    input  logic [IDX_W-1:0] nudge_idx,
    input  logic [REF_W-1:0] ref_mhz,
    output logic [BND_W-1:0] lower,
    output logic [BND_W-1:0] upper
);
    logic [BND_W-1:0] lower_q, lower_d;
    logic [BND_W-1:0] step;
    logic [BND_W-1:0] delta;

    generate
        if (DELTA_SLOW == DELTA_FAST) begin : g_fixed_delta
            assign delta = BND_W'(DELTA_SLOW);
        end else begin : g_split_delta
            assign delta = (32'(ref_mhz) < SPLIT_MHZ) ? BND_W'(DELTA_SLOW)
                                                      : BND_W'(DELTA_FAST);
        end
    endgenerate

    always_comb begin
        lower_d = lower_q;
        step    = BND_W'(nudge_idx >> 1);
        if (load) begin
            lower_d = base;
        end else if (nudge) begin
            if (nudge_idx[0]) lower_d = lower_q - step;
            else              lower_d = lower_q + step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lower_q <= '0;
        else        lower_q <= lower_d;
    end

    assign lower = lower_q;
    assign upper = lower_q + delta;

    // R2
    step_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> lower == $past(base));
endmodule

// File: rtl/cal_lock_monitor.sv
module cal_lock_monitor #(
    parameter int unsigned POLL_CYCLES  = 50,
    parameter int unsigned LOCK_POLLS   = 20480,
    parameter int unsigned HOLD_SAMPLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic ready,
    output logic res_valid,
    output logic res_pass
);
    import cal_pkg::*;

    localparam int unsigned TICK_W = $clog2(POLL_CYCLES + 1);
    localparam int unsigned POLL_W = $clog2(LOCK_POLLS + 1);
    localparam int unsigned HOLD_W = $clog2(HOLD_SAMPLES + 1);

    typedef struct packed {
        lock_phase_e       phase;
        logic [TICK_W-1:0] tick;
        logic [POLL_W-1:0] polls;
        logic [HOLD_W-1:0] holds;
        logic              res_valid;
        logic              res_pass;
    } mon_s;

    mon_s q, d;

    always_comb begin
        d           = q;
        d.res_valid = 1'b0;
        case (q.phase)
            LM_IDLE: begin
                if (go) begin
                    d.phase = LM_POLL;
                    d.tick  = '0;
                    d.polls = '0;
                end
            end
            LM_POLL: begin
                if (q.tick == TICK_W'(POLL_CYCLES - 1)) begin
                    d.tick = '0;
                    if (ready) begin
                        d.phase = LM_HOLD;
                        d.holds = '0;
                    end else if (q.polls == POLL_W'(LOCK_POLLS - 1)) begin
                        d.phase     = LM_IDLE;
                        d.res_valid = 1'b1;
                        d.res_pass  = 1'b0;
                    end else begin
                        d.polls = q.polls + 1'b1;
                    end
                end else begin
                    d.tick = q.tick + 1'b1;
                end
            end
            LM_HOLD: begin
                if (!ready) begin
                    d.phase     = LM_IDLE;
                    d.res_valid = 1'b1;
                    d.res_pass  = 1'b0;
                end else if (q.holds == HOLD_W'(HOLD_SAMPLES - 1)) begin
                    d.phase     = LM_IDLE;
                    d.res_valid = 1'b1;
                    d.res_pass  = 1'b1;
                end else begin
                    d.holds = q.holds + 1'b1;
                end
            end
            default: d.phase = LM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: LM_IDLE, default: '0};
        else        q <= d;
    end

    assign res_valid = q.res_valid;
    assign res_pass  = q.res_pass;

    // R6
    pass_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_pass) |-> $past(ready));

    // R5
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.polls < POLL_W'(LOCK_POLLS));
endmodule

// File: rtl/dpll_cal_seq.sv
module dpll_cal_seq #(
    parameter int unsigned REF_W        = 8,
    parameter int unsigned BND_W        = 16,
    parameter int unsigned CLK_MULT     = 48,
    parameter int unsigned POLL_CYCLES  = 50,
    parameter int unsigned LOCK_POLLS   = 20480,
    parameter int unsigned HOLD_SAMPLES = 4096,
    parameter int unsigned MAX_TRIES    = 8,
    parameter int unsigned SPLIT_MHZ    = 50,
    parameter int unsigned DELTA_SLOW   = 2,
    parameter int unsigned DELTA_FAST   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [REF_W-1:0]     ref_mhz,
    input  logic [REF_W-1:0]     tgt_mhz,
    input  logic [7:0]           stat_byte,
    output logic                 ctrl_wr,
    output logic [2*BND_W-1:0]   ctrl_word,
    output logic                 busy,
    output logic                 cal_ok,
    output logic                 cal_fail
);
    import cal_pkg::*;

    localparam int unsigned WORD_W = 2 * BND_W;
    localparam int unsigned ATT_W  = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
    localparam int unsigned TW_W   = $clog2(MAX_TRIES + 1) + 1;
    localparam logic [BND_W-1:0] TUNE_MASK = BND_W'(1) << TUNE_BIT;

    typedef struct packed {
        seq_state_e        st;
        logic [ATT_W-1:0]  att;
        logic [REF_W-1:0]  ref_l;
        logic              wr;
        logic [WORD_W-1:0] word;
        logic              ok;
        logic              fail;
        logic [TW_W-1:0]   tune_cnt;
    } seq_s;

    seq_s q, d;

    logic             div_go, div_done;
    logic [BND_W-1:0] div_num, div_quo;
    logic             step_load, step_nudge;
    logic [BND_W-1:0] lower, upper;
    logic             mon_go, res_valid, res_pass;

    assign div_num = BND_W'(ref_mhz) * BND_W'(CLK_MULT);

    cal_divider #(.NUM_W(BND_W), .DEN_W(REF_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .num  (div_num),
        .den  (tgt_mhz),
        .done (div_done),
        .quo  (div_quo)
    );

    cal_bound_stepper #(
        .BND_W     (BND_W),
        .REF_W     (REF_W),
        .IDX_W     (ATT_W),
        .SPLIT_MHZ (SPLIT_MHZ),
        .DELTA_SLOW(DELTA_SLOW),
        .DELTA_FAST(DELTA_FAST)
    ) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (step_load),
        .base     (div_quo),
        .nudge    (step_nudge),
        .nudge_idx(q.att),
        .ref_mhz  (q.ref_l),
        .lower    (lower),
        .upper    (upper)
    );

    cal_lock_monitor #(
        .POLL_CYCLES (POLL_CYCLES),
        .LOCK_POLLS  (LOCK_POLLS),
        .HOLD_SAMPLES(HOLD_SAMPLES)
    ) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (mon_go),
        .ready    (stat_byte[READY_BIT]),
        .res_valid(res_valid),
        .res_pass (res_pass)
    );

    always_comb begin
        d          = q;
        d.wr       = 1'b0;
        div_go     = 1'b0;
        step_load  = 1'b0;
        step_nudge = 1'b0;
        mon_go     = 1'b0;
        if (q.wr && q.word[TUNE_BIT]) d.tune_cnt = q.tune_cnt + 1'b1;
        case (q.st)
            SQ_IDLE: begin
                if (start) begin
                    div_go     = 1'b1;
                    d.ref_l    = ref_mhz;
                    d.att      = '0;
                    d.ok       = 1'b0;
                    d.fail     = 1'b0;
                    d.tune_cnt = '0;
                    d.st       = SQ_DIV;
                end
            end
            SQ_DIV: begin
                if (div_done) begin
                    step_load = 1'b1;
                    d.st      = SQ_ARM;
                end
            end
            SQ_ARM: begin
                d.wr   = 1'b1;
                d.word = {upper, lower | TUNE_MASK};
                mon_go = 1'b1;
                d.st   = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (res_valid) begin
                    if (res_pass) begin
                        d.wr   = 1'b1;
                        d.word = {upper, lower & ~TUNE_MASK};
                        d.ok   = 1'b1;
                        d.st   = SQ_IDLE;
                    end else if (q.att == ATT_W'(MAX_TRIES - 1)) begin
                        d.fail = 1'b1;
                        d.st   = SQ_IDLE;
                    end else begin
                        step_nudge = 1'b1;
                        d.att      = q.att + 1'b1;
                        d.st       = SQ_ARM;
                    end
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: SQ_IDLE, default: '0};
        else        q <= d;
    end

    assign ctrl_wr   = q.wr;
    assign ctrl_word = q.word;
    assign busy      = (q.st != SQ_IDLE);
    assign cal_ok    = q.ok;
    assign cal_fail  = q.fail;

    // R10
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_ok && cal_fail));

    // R7
    seal_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_ok) |-> (ctrl_wr && !ctrl_word[TUNE_BIT] && !busy));

    // R9
    tries_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_fail) |-> (q.tune_cnt == TW_W'(MAX_TRIES)));

    // R4
    tune_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_word[TUNE_BIT]) |-> busy);
endmodule

// File: tb/sim_dpll_cal_seq.sv
module sim_dpll_cal_seq;
    localparam int CLK_PERIOD = 10;
    localparam int POLLC = 2;
    localparam int LOCKP = 16;
    localparam int HOLDS = 8;
    localparam int TRIES = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  ref_mhz = 8'd0;
    logic [7:0]  tgt_mhz = 8'd1;
    logic [7:0]  stat_byte = 8'h7F;
    logic        ctrl_wr;
    logic [31:0] ctrl_word;
    logic        busy, cal_ok, cal_fail;

    int nchk = 0;
    int nfail = 0;
    int lk_delay [TRIES];
    int lk_drop  [TRIES];
    logic [31:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dpll_cal_seq #(
        .POLL_CYCLES (POLLC),
        .LOCK_POLLS  (LOCKP),
        .HOLD_SAMPLES(HOLDS),
        .MAX_TRIES   (TRIES)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_mhz(ref_mhz),
        .tgt_mhz(tgt_mhz), .stat_byte(stat_byte), .ctrl_wr(ctrl_wr),
        .ctrl_word(ctrl_word), .busy(busy), .cal_ok(cal_ok), .cal_fail(cal_fail)
    );

    task automatic check(bit cond, string req, logic [31:0] act, logic [31:0] expv);
        nchk++;
        if (!cond) begin
            nfail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    // PLL model: ready (bit 7) follows the per-attempt schedule; low bits are junk
    always @(negedge clk) begin : pll_model
        static int widx = 0;
        static int cur = 0;
        static int cyc = 0;
        static bit active = 1'b0;
        bit rdy;
        if (start) begin
            widx = 0;
            active = 1'b0;
        end
        if (ctrl_wr && ctrl_word[8]) begin
            cur = (widx < TRIES) ? widx : TRIES - 1;
            widx++;
            cyc = 0;
            active = 1'b1;
        end else if (active) begin
            cyc++;
        end
        rdy = active && lk_delay[cur] >= 0 && cyc >= lk_delay[cur] &&
              (lk_drop[cur] < 0 || cyc < lk_delay[cur] + lk_drop[cur]);
        stat_byte = rdy ? 8'h80 : 8'h7F;
    end

    // Scoreboard monitor: every control write is compared in order
    always @(negedge clk) begin : sb_mon
        logic [31:0] e;
        if (rst_n && ctrl_wr) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7/R9 unexpected write", ctrl_word, 32'h0);
            end else begin
                e = exp_q.pop_front();
                check(ctrl_word == e, "R2/R3/R4/R8 control word", ctrl_word, e);
            end
        end
    end

    task automatic push_word(int up, int lo, bit tune);
        logic [31:0] w;
        w = {up[15:0], lo[15:0]};
        if (tune) w[8] = 1'b1;
        else      w[8] = 1'b0;
        exp_q.push_back(w);
    endtask

    task automatic set_sched(int k, int dly, int drp);
        lk_delay[k] = dly;
        lk_drop[k]  = drp;
    endtask

    task automatic run_case(int rf, int tg, bit exp_ok);
        int n;
        ref_mhz = rf[7:0];
        tgt_mhz = tg[7:0];
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R10: flags cleared once the run is accepted
        check(busy && !cal_ok && !cal_fail, "R10 flags cleared on start",
              {29'd0, busy, cal_ok, cal_fail}, 32'h4);
        n = 0;
        while (!(cal_ok || cal_fail) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(cal_ok == exp_ok && cal_fail == !exp_ok && !busy, "R7/R9 outcome",
              {29'd0, busy, cal_ok, cal_fail}, {30'd0, exp_ok, !exp_ok});
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R7/R9 write count", exp_q.size(), 32'd0);
        check(!(cal_ok && cal_fail), "R10 exclusive", {30'd0, cal_ok, cal_fail}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin : driver
        int lo;
        int d;
        for (int k = 0; k < TRIES; k++) set_sched(k, -1, -1);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!ctrl_wr && !busy && !cal_ok && !cal_fail, "R1 reset state",
              {28'd0, ctrl_wr, busy, cal_ok, cal_fail}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ctrl_wr && !busy && !cal_ok && !cal_fail, "R1 after reset release",
              {28'd0, ctrl_wr, busy, cal_ok, cal_fail}, 32'd0);

        // Case A: R2 R3 R4 R7, ref 33 < 50 so delta 2, lower = 1584/50 = 31
        set_sched(0, 5, -1);
        push_word(33, 31, 1'b1);
        push_word(33, 31, 1'b0);
        run_case(33, 50, 1'b1);

        // Case B: R5 timeouts, R6 drop in window, R8 nudge; lower 48, delta 4
        for (int k = 0; k < TRIES; k++) set_sched(k, -1, -1);
        set_sched(2, 2, 3);
        set_sched(3, 1, -1);
        push_word(52, 48, 1'b1);
        push_word(52, 48, 1'b1);
        push_word(52, 48, 1'b1);
        push_word(53, 49, 1'b1);
        push_word(53, 49, 1'b0);
        run_case(66, 66, 1'b1);

        // Case C: R9 all attempts fail, R8 full nudge pattern, R3 ref 50 -> delta 4
        for (int k = 0; k < TRIES; k++) set_sched(k, -1, -1);
        lo = (50 * 48) / 50;
        d = 4;
        for (int k = 0; k < TRIES; k++) begin
            push_word(lo + d, lo, 1'b1);
            if (k % 2 == 1) lo = lo - (k / 2);
            else            lo = lo + (k / 2);
        end
        run_case(50, 50, 1'b0);

        // Case D: R10 restart after failure clears cal_fail; immediate lock
        for (int k = 0; k < TRIES; k++) set_sched(k, -1, -1);
        set_sched(0, 0, -1);
        push_word(42, 40, 1'b1);
        push_word(42, 40, 1'b0);
        run_case(40, 48, 1'b1);

        // Case E: R3 boundary ref 49 -> delta 2, lower = 2352/66 = 35
        for (int k = 0; k < TRIES; k++) set_sched(k, -1, -1);
        set_sched(0, 3, -1);
        push_word(37, 35, 1'b1);
        push_word(37, 35, 1'b0);
        run_case(49, 66, 1'b1);

        summary();
        $finish;
    end
endmodule